// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Cache

This block keeps the bookkeeping that lets a data cache continue working while line fetches are in flight to memory. Every line miss the cache hands over is either given a fresh tracking entry or folded into the entry already open for that line. Each fresh entry sends one line request toward memory, tagged with the entry number. When memory answers with that number, the block lists the requester IDs that were waiting, one per cycle, and then frees the entry for reuse.

A two-bit mode input sets how much concurrency the cache gets. In the strictest mode the cache waits for every outstanding miss to finish before it accepts anything new. In the middle mode hits still go through but a second miss waits. In the loosest mode misses keep allocating entries and merging until storage runs out. The cache reads `stall_o` in the same cycle it presents a request. A request counts as taken only when `stall_o` is low.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is open: `stall_o` is low, `mem_req_valid_o` and `wake_valid_o` are low, and `fill_ready_o` is high.
- R2: An accepted miss to a line with no open entry takes the lowest-numbered free entry. From the next cycle that entry's request is offered on the memory channel, carrying the line address and the entry number as transaction ID.
- R3: Memory requests are offered one at a time, in the order their entries were allocated. A request is retired on a cycle where `mem_req_valid_o` and `mem_req_ready_i` are both high.
- R4: In miss-under-miss mode, a miss to a line whose entry is open and not yet filled is merged into that entry as long as it holds fewer than N_TARGETS requester IDs. A merge sends no second memory request. Once the entry holds N_TARGETS IDs, a further miss to that line stalls.
- R5: In miss-under-miss mode, a miss to a line with no open entry stalls when every entry is in use.
- R6: In stall-under-miss mode (mode 0), any request, hit or miss, stalls while any entry is open.
- R7: In hit-under-miss mode (mode 1), hits never stall, and a miss stalls while any entry is open.
- R8: A fill is taken on a cycle where `fill_valid_i` and `fill_ready_o` are both high. Starting the next cycle, `wake_valid_o` is high for one cycle per waiting requester and `wake_id_o` gives the IDs in the order the requests were accepted. `fill_ready_o` stays low while this runs.
- R9: An entry is freed on the cycle its last ID is reported. From the next cycle it can be allocated again, and it then reuses its entry number as transaction ID.
- R10: In miss-under-miss mode, a miss to a line whose entry has already received its fill stalls until that entry is freed.
- R11: Mode value 2 and mode value 3 both select miss-under-miss behaviour.
- R12: An accepted hit changes nothing: no entry, no memory request and no wake-up result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 stall-under-miss, 1 hit-under-miss, 2 or 3 miss-under-miss |
| req_valid_i | input | 1 | Cache presents an access |
| req_hit_i | input | 1 | The access hit in the cache |
| req_line_i | input | LINE_W | Line address of the access |
| req_id_i | input | ID_W | Requester ID of the access |
| stall_o | output | 1 | Access not taken this cycle |
| mem_req_valid_o | output | 1 | Line request offered to memory |
| mem_req_ready_i | input | 1 | Memory takes the offered request |
| mem_req_line_o | output | LINE_W | Line address of the offered request |
| mem_req_tid_o | output | IDX_W | Entry number used as transaction ID |
| fill_valid_i | input | 1 | Memory returns a line |
| fill_tid_i | input | IDX_W | Transaction ID of the returned line |
| fill_ready_o | output | 1 | A fill can be taken |
| wake_valid_o | output | 1 | A waiting requester is released |
| wake_id_o | output | ID_W | ID of the released requester |

## Verification
Two pairs of events can land in the same cycle. A merge into an entry can coincide with that entry's fill being taken or its request being retired. An allocation can coincide with the final wake-up that frees a different entry. The bench provokes both with random traffic over a small pool of line addresses, random memory readiness and random fill choices, so merges, retirements and drains overlap often. A cycle-level model in the bench applies every event of a cycle against the state at the start of that cycle. It then judges stall, the request head and each wake-up ID. For example, a merge taken together with the fill must show up as one extra wake-up.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    MODE_STALL_ON_MISS  = 2'd0,
    MODE_HIT_UNDER_MISS = 2'd1,
    MODE_MISS_UNDER_A   = 2'd2,
    MODE_MISS_UNDER_B   = 2'd3
  } miss_mode_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int LINE_W    = 26,
  parameter int ID_W      = 4,
  parameter int N_TARGETS = 4,
  parameter int CNT_W     = $clog2(N_TARGETS + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             alloc_i,
  input  logic                             merge_i,
  input  logic                             fill_i,
  input  logic                             free_i,
  input  logic [LINE_W-1:0]                line_i,
  input  logic [ID_W-1:0]                  id_i,
  output logic                             valid_o,
  output logic                             filled_o,
  output logic [LINE_W-1:0]                line_o,
  output logic [CNT_W-1:0]                 cnt_o,
  output logic [N_TARGETS-1:0][ID_W-1:0]   tgt_o
);
  logic                           valid_q, filled_q;
  logic [LINE_W-1:0]              line_q;
  logic [CNT_W-1:0]               cnt_q;
  logic [N_TARGETS-1:0][ID_W-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      filled_q <= 1'b0;
      line_q   <= '0;
      cnt_q    <= '0;
      tgt_q    <= '0;
    end else if (free_i) begin
      valid_q  <= 1'b0;
      filled_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (alloc_i) begin
        valid_q  <= 1'b1;
        line_q   <= line_i;
        cnt_q    <= CNT_W'(1);
        tgt_q[0] <= id_i;
      end
      if (merge_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
        for (int t = 0; t < N_TARGETS; t++)
          if (CNT_W'(t) == cnt_q) tgt_q[t] <= id_i;
      end
      if (fill_i) filled_q <= 1'b1;
    end
  end

  assign valid_o  = valid_q;
  assign filled_o = filled_q;
  assign line_o   = line_q;
  assign cnt_o    = cnt_q;
  assign tgt_o    = tgt_q;

  // R5: only a free slot is ever allocated
  a_r5_alloc_free_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q);
  // R4: merges only into an open, unfilled entry with room
  a_r4_merge_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |-> (valid_q && !filled_q && cnt_q < CNT_W'(N_TARGETS)));
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_TARGETS));
  // R8: a fill lands on an open entry once
  a_r8_fill_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> (valid_q && !filled_q));
  // R9: freeing closes the slot
  a_r9_free_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |=> !valid_q);
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int N_ENTRIES = 4,
  parameter int LINE_W    = 26,
  parameter int N_TARGETS = 4,
  parameter int CNT_W     = $clog2(N_TARGETS + 1),
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_ENTRIES-1:0]               valid_i,
  input  logic [N_ENTRIES-1:0]               filled_i,
  input  logic [N_ENTRIES-1:0][LINE_W-1:0]   lines_i,
  input  logic [N_ENTRIES-1:0][CNT_W-1:0]    cnts_i,
  input  logic [LINE_W-1:0]                  req_line_i,
  output logic                               match_any_o,
  output logic [IDX_W-1:0]                   match_idx_o,
  output logic                               match_blocked_o,
  output logic                               free_any_o,
  output logic [IDX_W-1:0]                   free_idx_o
);
  logic [N_ENTRIES-1:0] match_vec, blocked_vec;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign match_vec[i]   = valid_i[i] && (lines_i[i] == req_line_i);
    assign blocked_vec[i] = filled_i[i] || (cnts_i[i] == CNT_W'(N_TARGETS));
  end

  assign match_any_o     = |match_vec;
  assign match_blocked_o = |(match_vec & blocked_vec);
  assign free_any_o      = ~&valid_i;

  always_comb begin
    match_idx_o = '0;
    free_idx_o  = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) match_idx_o = IDX_W'(i);
      if (!valid_i[i])  free_idx_o  = IDX_W'(i);
    end
  end

  // R4: a line never owns two open entries
  a_r4_unique_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));
endmodule

// File: rtl/mshr_order_fifo.sv
module mshr_order_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [PTR_W-1:0]        rd_q, wr_q;
  logic [PTR_W:0]          used_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      used_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= bump(wr_q);
      end
      if (pop_i) rd_q <= bump(rd_q);
      used_q <= used_q + (PTR_W+1)'(push_i) - (PTR_W+1)'(pop_i);
    end
  end

  assign valid_o = (used_q != '0);
  assign data_o  = mem_q[rd_q];

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (used_q < (PTR_W+1)'(DEPTH) || pop_i));
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o);
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int N_TARGETS = 4,
  parameter int LINE_W    = 26,
  parameter int ID_W      = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int CNT_W    = $clog2(N_TARGETS + 1),
  localparam int PTR_W    = (N_TARGETS > 1) ? $clog2(N_TARGETS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              req_valid_i,
  input  logic              req_hit_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              stall_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [LINE_W-1:0] mem_req_line_o,
  output logic [IDX_W-1:0]  mem_req_tid_o,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_tid_i,
  output logic              fill_ready_o,
  output logic              wake_valid_o,
  output logic [ID_W-1:0]   wake_id_o
);
  logic [N_ENTRIES-1:0]                           e_valid, e_filled;
  logic [N_ENTRIES-1:0][LINE_W-1:0]               e_line;
  logic [N_ENTRIES-1:0][CNT_W-1:0]                e_cnt;
  logic [N_ENTRIES-1:0][N_TARGETS-1:0][ID_W-1:0]  e_tgt;

  logic             match_any, match_blocked, free_any;
  logic [IDX_W-1:0] match_idx, free_idx, head_idx;
  logic             req_miss, any_busy, accept_miss, do_merge, do_alloc;
  logic             fill_acc, drain_last, issue;
  logic             drain_active;
  logic [IDX_W-1:0] drain_idx;
  logic [PTR_W-1:0] drain_ptr;
  miss_mode_e       mode;

  assign mode     = miss_mode_e'(mode_i);
  assign req_miss = req_valid_i && !req_hit_i;
  assign any_busy = |e_valid;

  mshr_lookup #(
    .N_ENTRIES(N_ENTRIES), .LINE_W(LINE_W), .N_TARGETS(N_TARGETS),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_lookup (
    .clk_i, .rst_ni,
    .valid_i(e_valid), .filled_i(e_filled), .lines_i(e_line), .cnts_i(e_cnt),
    .req_line_i,
    .match_any_o(match_any), .match_idx_o(match_idx),
    .match_blocked_o(match_blocked),
    .free_any_o(free_any), .free_idx_o(free_idx)
  );

  always_comb begin
    unique case (mode)
      MODE_STALL_ON_MISS:  stall_o = req_valid_i && any_busy;
      MODE_HIT_UNDER_MISS: stall_o = req_miss && any_busy;
      default:             stall_o = req_miss && (match_any ? match_blocked : !free_any);
    endcase
  end

  assign accept_miss = req_miss && !stall_o;
  assign do_merge    = accept_miss && match_any;
  assign do_alloc    = accept_miss && !match_any;

  assign fill_ready_o = !drain_active;
  assign fill_acc     = fill_valid_i && !drain_active;
  assign drain_last   = drain_active &&
                        ((CNT_W'(drain_ptr) + CNT_W'(1)) == e_cnt[drain_idx]);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    mshr_entry #(
      .LINE_W(LINE_W), .ID_W(ID_W), .N_TARGETS(N_TARGETS), .CNT_W(CNT_W)
    ) u_entry (
      .clk_i, .rst_ni,
      .alloc_i (do_alloc && free_idx == IDX_W'(i)),
      .merge_i (do_merge && match_idx == IDX_W'(i)),
      .fill_i  (fill_acc && fill_tid_i == IDX_W'(i)),
      .free_i  (drain_last && drain_idx == IDX_W'(i)),
      .line_i  (req_line_i),
      .id_i    (req_id_i),
      .valid_o (e_valid[i]),
      .filled_o(e_filled[i]),
      .line_o  (e_line[i]),
      .cnt_o   (e_cnt[i]),
      .tgt_o   (e_tgt[i])
    );
  end

  assign issue = mem_req_valid_o && mem_req_ready_i;

  mshr_order_fifo #(.DEPTH(N_ENTRIES), .W(IDX_W)) u_order (
    .clk_i, .rst_ni,
    .push_i(do_alloc), .data_i(free_idx),
    .pop_i(issue), .valid_o(mem_req_valid_o), .data_o(head_idx)
  );

  assign mem_req_tid_o  = head_idx;
  assign mem_req_line_o = e_line[head_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_active <= 1'b0;
      drain_idx    <= '0;
      drain_ptr    <= '0;
    end else if (fill_acc) begin
      drain_active <= 1'b1;
      drain_idx    <= fill_tid_i;
      drain_ptr    <= '0;
    end else if (drain_active) begin
      if (drain_last) drain_active <= 1'b0;
      else            drain_ptr    <= drain_ptr + PTR_W'(1);
    end
  end

  assign wake_valid_o = drain_active;
  always_comb begin
    wake_id_o = '0;
    for (int t = 0; t < N_TARGETS; t++)
      if (PTR_W'(t) == drain_ptr) wake_id_o = e_tgt[drain_idx][t];
  end

  // R2: an allocation is offered to memory the next cycle
  a_r2_alloc_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_alloc |=> mem_req_valid_o);
  // R8: a fill must name an open entry that has not yet been filled
  a_r8_fill_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_acc |-> (e_valid[fill_tid_i] && !e_filled[fill_tid_i]));
  // R8: wake-ups come only from a filled entry
  a_r8_wake_from_filled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_valid_o |-> (e_valid[drain_idx] && e_filled[drain_idx]));
  // R3: the offered request is for an open entry not yet filled
  a_r3_head_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (e_valid[head_idx] && !e_filled[head_idx]));
endmodule

// File: tb/mshr_file_test.sv
module mshr_file_test;
  localparam int NE = 4, NT = 4, LW = 26, IW = 4, XW = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [1:0]    mode_i = '0;
  logic          req_valid = 1'b0, req_hit = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic [IW-1:0] req_id = '0;
  logic          stall, mreq_valid, mreq_ready = 1'b0;
  logic [LW-1:0] mreq_line;
  logic [XW-1:0] mreq_tid, fill_tid = '0;
  logic          fill_valid = 1'b0, fill_ready, wake_valid;
  logic [IW-1:0] wake_id;

  always #5 clk = ~clk;

  mshr_file #(.N_ENTRIES(NE), .N_TARGETS(NT), .LINE_W(LW), .ID_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i),
    .req_valid_i(req_valid), .req_hit_i(req_hit), .req_line_i(req_line),
    .req_id_i(req_id), .stall_o(stall),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_line_o(mreq_line), .mem_req_tid_o(mreq_tid),
    .fill_valid_i(fill_valid), .fill_tid_i(fill_tid), .fill_ready_o(fill_ready),
    .wake_valid_o(wake_valid), .wake_id_o(wake_id)
  );

  int total = 0, bad = 0, mode = 2;
  bit done = 0;
  bit m_v[NE], m_f[NE];
  int m_line[NE], m_cnt[NE], m_tgt[NE][NT];
  int m_q[$], outq[$];
  bit dr_act = 0;
  int dr_idx = 0, dr_ptr = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d exp %0d", tag, what, act, exp);
    end
  endtask

  function automatic int find_match(int line);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_line[i] == line) return i;
    return -1;
  endfunction

  function automatic int find_free();
    for (int i = 0; i < NE; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  function automatic bit model_busy();
    for (int i = 0; i < NE; i++) if (m_v[i]) return 1;
    return 0;
  endfunction

  // fsel: -1 no fill, -2 random outstanding, else that transaction ID
  task automatic step(bit rv, bit hit, int line, int id, bit mrdy, int fsel);
    int k, mi, fr;
    bit es, busy, facc;
    string tg;
    @(negedge clk);
    k = -1;
    if (fsel == -2 && outq.size() > 0) k = int'($urandom % outq.size());
    else if (fsel >= 0)
      for (int j = 0; j < outq.size(); j++) if (outq[j] == fsel) k = j;
    mode_i     = 2'(mode);
    req_valid  = rv;
    req_hit    = hit;
    req_line   = LW'(line);
    req_id     = IW'(id);
    mreq_ready = mrdy;
    fill_valid = (k >= 0);
    fill_tid   = (k >= 0) ? XW'(outq[k]) : '0;
    #1;
    busy = model_busy();
    mi = find_match(line);
    fr = find_free();
    if (!rv) begin es = 0; tg = "R1"; end
    else if (mode == 0) begin es = busy; tg = "R6"; end
    else if (mode == 1) begin es = !hit && busy; tg = "R7"; end
    else begin
      if (hit) begin es = 0; tg = "R12"; end
      else if (mi >= 0) begin es = m_f[mi] || m_cnt[mi] == NT; tg = m_f[mi] ? "R10" : "R4"; end
      else begin es = (fr < 0); tg = es ? "R5" : "R2"; end
      if (mode == 3) tg = {tg, " R11"};
    end
    chk(tg, "stall", int'(stall), int'(es));
    chk("R3 R12", "mem_req_valid", int'(mreq_valid), int'(m_q.size() > 0));
    if (m_q.size() > 0) begin
      chk("R3 R9", "mem_req_tid", int'(mreq_tid), m_q[0]);
      chk("R2", "mem_req_line", int'(mreq_line), m_line[m_q[0]]);
    end
    chk("R8", "fill_ready", int'(fill_ready), int'(!dr_act));
    chk("R8", "wake_valid", int'(wake_valid), int'(dr_act));
    if (dr_act) chk("R8", "wake_id", int'(wake_id), m_tgt[dr_idx][dr_ptr]);
    // next state, all decisions from start-of-cycle state
    facc = (k >= 0) && !dr_act;
    if (dr_act) begin
      if (dr_ptr == m_cnt[dr_idx] - 1) begin
        m_v[dr_idx] = 0; m_f[dr_idx] = 0; m_cnt[dr_idx] = 0; dr_act = 0;
      end else dr_ptr++;
    end
    if (facc) begin
      m_f[outq[k]] = 1; dr_act = 1; dr_idx = outq[k]; dr_ptr = 0;
      outq.delete(k);
    end
    if (m_q.size() > 0 && mrdy) outq.push_back(m_q.pop_front());
    if (rv && !es && !hit) begin
      if (mi >= 0) begin
        m_tgt[mi][m_cnt[mi]] = id; m_cnt[mi]++;
      end else begin
        m_v[fr] = 1; m_f[fr] = 0; m_line[fr] = line; m_cnt[fr] = 1;
        m_tgt[fr][0] = id; m_q.push_back(fr);
      end
    end
  endtask

  task automatic flush();
    for (int n = 0; n < 400; n++) begin
      if (!model_busy() && !dr_act) break;
      step(0, 0, 0, 0, 1, -2);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 exp 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_f[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "stall in reset", int'(stall), 0);
    chk("R1", "mem_req_valid in reset", int'(mreq_valid), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, -1);                    // R1 idle after reset
    // directed, miss-under-miss
    mode = 2;
    step(1, 0, 1, 3, 0, -1);                    // R2 alloc entry 0
    step(1, 0, 1, 5, 0, -1);                    // R4 merges
    step(1, 0, 1, 6, 0, -1);
    step(1, 0, 1, 7, 0, -1);
    step(1, 0, 1, 8, 0, -1);                    // R4 targets full, stall
    step(1, 0, 2, 9, 0, -1);
    step(1, 0, 3, 10, 0, -1);
    step(1, 0, 4, 11, 0, -1);
    step(1, 0, 5, 12, 0, -1);                   // R5 all entries busy
    step(1, 1, 9, 13, 0, -1);                   // R12 hit passes
    repeat (4) step(0, 0, 0, 0, 1, -1);         // R3 issue in order
    step(0, 0, 0, 0, 0, 0);                     // R8 fill entry 0
    step(1, 0, 1, 14, 0, 2);                    // R10 miss to drained line, fill refused
    repeat (4) step(0, 0, 0, 0, 0, -1);         // R8 wake ids in order
    step(1, 0, 6, 15, 0, -1);                   // R9 reuse entry 0
    step(0, 0, 0, 0, 1, -1);
    flush();
    mode = 0;                                   // R6
    step(1, 0, 7, 1, 0, -1);
    step(1, 1, 7, 2, 0, -1);
    flush();
    // random phases in every mode
    for (int md = 0; md < 4; md++) begin
      mode = md;
      for (int n = 0; n < 700; n++)
        step(($urandom % 10) < 7, ($urandom % 10) < 3, int'($urandom % 6),
             int'($urandom % 16), ($urandom % 2) == 1,
             (($urandom % 10) < 3) ? -2 : -1);
      flush();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule